// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds a small set of processor control and status registers and serves them through a single access port. Each access gives a register index, a read strobe or a write strobe, and write data. It also gives the privilege mode and the trap level that the core is currently running at. The block returns read data and a fault code in the same cycle. Writes are committed on the next rising clock edge, and only if the access raised no fault.

The bank contains the following registers:

- A soft-interrupt register. It has two alias indices: one ORs the write data into the register, and the other clears the bits that are set in the write data.
- Two timer-compare registers that non-privileged code may not touch.
- A hyper trap-state register. It can be used only while a trap is being handled.
- A hyper trap-base register whose low bits always read as zero.
- A read-only version word built from parameters.

When a soft-interrupt write raises the highest pending interrupt level, the block emits a one-cycle pulse. This pulse tells the core to re-examine its pending interrupts.

Top module: `ctrl_reg_bank`

## Requirements
- R1: A write to index 2 (clear alias) sets the soft-interrupt register to its previous value AND the inverse of the write data.
- R2: A write to index 1 (set alias) sets the soft-interrupt register to its previous value OR the write data.
- R3: When the privilege mode is 0 (non-privileged), a read or write of index 0, 3 or 4, or a write of index 1 or 2, returns fault code 1 (privileged-opcode). The target register then keeps its value.
- R4: Any access to index 5 (hyper trap-state) while the trap level is 0 returns fault code 2 (illegal-instruction), and the register keeps its value.
- R5: A write to index 6 (hyper trap-base) stores the data with bits [14:0] forced to zero, and a read returns those bits as zero.
- R6: Index 7 (version) reads as {MAX_GL in bits [23:16], MAX_TL in bits [15:8], NWIN in bits [7:0]}. A write to index 7 returns fault code 2.
- R7: Indices 8 to 15, and reads of indices 1 and 2, return fault code 2. Every read that faults returns zero data. With no strobe, the fault code is 0.
- R8: `irq_recheck_o` is high for exactly the one cycle after the clock edge that commits a soft-interrupt write (index 0, 1 or 2). It is high only when the new level is greater than the old one. The level is the position of the highest set bit among bits [15:1], or 0 when none of those bits is set.
- R9: After reset, every register reads as zero and `irq_recheck_o` is low.
- R10: A fault-free write to index 0, 3, 4 or 5 stores the write data unchanged, and a later read of that index returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_i | input | 4 | Register index |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wr_data_i | input | DW | Write data |
| priv_i | input | 2 | Privilege mode: 0 non-privileged, 1 privileged, 2 hyper-privileged |
| tl_i | input | TL_W | Current trap level |
| rd_data_o | output | DW | Read data, zero when the read faults or no read is made |
| fault_o | output | 2 | 0 none, 1 privileged-opcode, 2 illegal-instruction |
| irq_recheck_o | output | 1 | One-cycle pulse when the soft-interrupt level rises |

## Verification
The soft-interrupt path is driven with writes that move the highest pending bit up, down, onto bit 0, or above bit 15. A pulse that fires on any change, or that counts bit 0 or bit 16 in the level, is therefore caught. The set and clear aliases are applied over a non-zero base value, so an alias that overwrites the register instead of merging into it gives a wrong read-back. Random accesses cover every index, privilege mode and trap level. This separates privileged-opcode faults from illegal-instruction faults, shows that faulting writes leave the register unchanged, and shows that faulting reads return zero.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;

  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    PM_USER  = 2'd0,
    PM_PRIV  = 2'd1,
    PM_HYPER = 2'd2,
    PM_RSVD  = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_PRIVOP  = 2'd1,
    FLT_ILLEGAL = 2'd2
  } fault_e;

  localparam logic [IDX_W-1:0] IX_SINT   = 4'd0;
  localparam logic [IDX_W-1:0] IX_SSET   = 4'd1;
  localparam logic [IDX_W-1:0] IX_SCLR   = 4'd2;
  localparam logic [IDX_W-1:0] IX_TCMP   = 4'd3;
  localparam logic [IDX_W-1:0] IX_SCMP   = 4'd4;
  localparam logic [IDX_W-1:0] IX_TSTATE = 4'd5;
  localparam logic [IDX_W-1:0] IX_TBASE  = 4'd6;
  localparam logic [IDX_W-1:0] IX_VER    = 4'd7;

  // Highest set bit among [15:1], 0 when none is set.
  function automatic logic [3:0] sint_level(input logic [15:0] v);
    logic [3:0] lvl;
    lvl = 4'd0;
    for (int i = 1; i < 16; i++) begin
      if (v[i]) lvl = 4'(i);
    end
    return lvl;
  endfunction

  // Next soft-interrupt value for a direct, set-alias or clear-alias write.
  function automatic logic [63:0] sint_next(input logic [IDX_W-1:0] ix,
                                            input logic [63:0] cur,
                                            input logic [63:0] d);
    logic [63:0] nv;
    case (ix)
      IX_SSET: nv = cur | d;
      IX_SCLR: nv = cur & ~d;
      default: nv = d;
    endcase
    return nv;
  endfunction

endpackage

// File: rtl/ctrl_access_decode.sv
module ctrl_access_decode
  import ctrl_reg_pkg::*;
#(
  parameter int TL_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       priv_i,
  input  logic [TL_W-1:0]  tl_i,
  output logic [1:0]       fault_o,
  output logic             wr_go_o
);

  logic user_mode;
  logic in_trap;
  logic rd_ill;
  logic wr_ill;
  logic need_priv;

  assign user_mode = (priv_i == PM_USER);
  assign in_trap   = (tl_i != '0);

  always_comb begin
    rd_ill    = 1'b0;
    wr_ill    = 1'b0;
    need_priv = 1'b0;
    case (idx_i)
      IX_SINT, IX_TCMP, IX_SCMP: need_priv = 1'b1;
      IX_SSET, IX_SCLR: begin
        rd_ill    = 1'b1;
        need_priv = 1'b1;
      end
      IX_TSTATE: begin
        rd_ill = !in_trap;
        wr_ill = !in_trap;
      end
      IX_TBASE: ;
      IX_VER:   wr_ill = 1'b1;
      default: begin
        rd_ill = 1'b1;
        wr_ill = 1'b1;
      end
    endcase
  end

  always_comb begin
    if ((rd_en_i && rd_ill) || (wr_en_i && wr_ill))
      fault_o = FLT_ILLEGAL;
    else if ((rd_en_i || wr_en_i) && need_priv && user_mode)
      fault_o = FLT_PRIVOP;
    else
      fault_o = FLT_NONE;
  end

  assign wr_go_o = wr_en_i && (fault_o == FLT_NONE);

endmodule

// File: rtl/ctrl_softint.sv
module ctrl_softint
  import ctrl_reg_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    sint_o,
  output logic             recheck_o
);

  logic [DW-1:0] sint_q;
  logic [DW-1:0] sint_nv;
  logic          sint_hit;
  logic [3:0]    lvl_old;
  logic [3:0]    lvl_new;

  assign sint_hit = wr_go_i &&
                    (idx_i == IX_SINT || idx_i == IX_SSET || idx_i == IX_SCLR);
  assign sint_nv  = DW'(sint_next(idx_i, 64'(sint_q), 64'(wr_data_i)));
  assign lvl_old  = sint_level(sint_q[15:0]);
  assign lvl_new  = sint_level(sint_nv[15:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sint_q    <= '0;
      recheck_o <= 1'b0;
    end else begin
      recheck_o <= sint_hit && (lvl_new > lvl_old);
      if (sint_hit) sint_q <= sint_nv;
    end
  end

  assign sint_o = sint_q;

endmodule

// File: rtl/ctrl_plain_regs.sv
module ctrl_plain_regs
  import ctrl_reg_pkg::*;
#(
  parameter int DW       = 64,
  parameter int LOW_ZERO = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    tcmp_o,
  output logic [DW-1:0]    scmp_o,
  output logic [DW-1:0]    tstate_o,
  output logic [DW-1:0]    tbase_o
);

  localparam int NREG = 4;
  localparam logic [DW-1:0] BASE_MASK = ~DW'((64'd1 << LOW_ZERO) - 64'd1);
  localparam logic [IDX_W-1:0] SLOT_IX [NREG] = '{IX_TCMP, IX_SCMP, IX_TSTATE, IX_TBASE};

  logic [DW-1:0] slot_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [DW-1:0] KEEP = (g == NREG - 1) ? BASE_MASK : '1;
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (wr_go_i && idx_i == SLOT_IX[g]) slot_q[g] <= wr_data_i & KEEP;
    end
  end

  assign tcmp_o   = slot_q[0];
  assign scmp_o   = slot_q[1];
  assign tstate_o = slot_q[2];
  assign tbase_o  = slot_q[3] & BASE_MASK;

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrl_reg_pkg::*;
#(
  parameter int DW       = 64,
  parameter int TL_W     = 3,
  parameter int LOW_ZERO = 15,
  parameter int NWIN     = 8,
  parameter int MAX_TL   = 6,
  parameter int MAX_GL   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      idx_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [1:0]      priv_i,
  input  logic [TL_W-1:0] tl_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [1:0]      fault_o,
  output logic            irq_recheck_o
);

  localparam logic [DW-1:0] VER_WORD =
    DW'({8'(MAX_GL), 8'(MAX_TL), 8'(NWIN)});

  logic          wr_go;
  logic [DW-1:0] sint_q;
  logic [DW-1:0] tcmp_q;
  logic [DW-1:0] scmp_q;
  logic [DW-1:0] tstate_q;
  logic [DW-1:0] tbase_q;
  logic [DW-1:0] rd_sel;

  ctrl_access_decode #(.TL_W(TL_W)) u_dec (
    .idx_i   (idx_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .priv_i  (priv_i),
    .tl_i    (tl_i),
    .fault_o (fault_o),
    .wr_go_o (wr_go)
  );

  ctrl_softint #(.DW(DW)) u_sint (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go_i   (wr_go),
    .idx_i     (idx_i),
    .wr_data_i (wr_data_i),
    .sint_o    (sint_q),
    .recheck_o (irq_recheck_o)
  );

  ctrl_plain_regs #(.DW(DW), .LOW_ZERO(LOW_ZERO)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go_i   (wr_go),
    .idx_i     (idx_i),
    .wr_data_i (wr_data_i),
    .tcmp_o    (tcmp_q),
    .scmp_o    (scmp_q),
    .tstate_o  (tstate_q),
    .tbase_o   (tbase_q)
  );

  always_comb begin
    case (idx_i)
      IX_SINT:   rd_sel = sint_q;
      IX_TCMP:   rd_sel = tcmp_q;
      IX_SCMP:   rd_sel = scmp_q;
      IX_TSTATE: rd_sel = tstate_q;
      IX_TBASE:  rd_sel = tbase_q;
      IX_VER:    rd_sel = VER_WORD;
      default:   rd_sel = '0;
    endcase
  end

  assign rd_data_o = (rd_en_i && fault_o == FLT_NONE) ? rd_sel : '0;

endmodule

// File: rtl/ctrl_reg_bank_chk.sv
module ctrl_reg_bank_chk #(
  parameter int DW       = 64,
  parameter int TL_W     = 3,
  parameter int LOW_ZERO = 15,
  parameter int NWIN     = 8,
  parameter int MAX_TL   = 6,
  parameter int MAX_GL   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      idx_i,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [DW-1:0]   wr_data_i,
  input logic [1:0]      priv_i,
  input logic [TL_W-1:0] tl_i,
  input logic [DW-1:0]   rd_data_o,
  input logic [1:0]      fault_o,
  input logic            irq_recheck_o,
  input logic [DW-1:0]   sint_q,
  input logic [DW-1:0]   tbase_q
);

  logic sint_commit;
  assign sint_commit = wr_en_i && fault_o == 2'd0 && idx_i <= 4'd2;

  a_r1_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (sint_commit && idx_i == 4'd2) |=> sint_q == ($past(sint_q) & ~$past(wr_data_i)));

  a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (sint_commit && idx_i == 4'd1) |=> sint_q == ($past(sint_q) | $past(wr_data_i)));

  a_r3_user_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && priv_i == 2'd0 && idx_i <= 4'd2) |=> $stable(sint_q));

  a_r4_trap_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en_i || wr_en_i) && idx_i == 4'd5 && tl_i == '0) |-> fault_o == 2'd2);

  a_r5_base_low: assert property (@(posedge clk) disable iff (!rst_n)
    tbase_q[LOW_ZERO-1:0] == '0);

  a_r6_version: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_en_i && idx_i == 4'd7) |->
      (rd_data_o[7:0] == 8'(NWIN) && rd_data_o[15:8] == 8'(MAX_TL) && rd_data_o[23:16] == 8'(MAX_GL)));

  a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && fault_o != 2'd0) |-> rd_data_o == '0);

  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_recheck_o |-> $past(sint_commit));

endmodule

bind ctrl_reg_bank ctrl_reg_bank_chk #(
  .DW(DW), .TL_W(TL_W), .LOW_ZERO(LOW_ZERO),
  .NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .idx_i         (idx_i),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .wr_data_i     (wr_data_i),
  .priv_i        (priv_i),
  .tl_i          (tl_i),
  .rd_data_o     (rd_data_o),
  .fault_o       (fault_o),
  .irq_recheck_o (irq_recheck_o),
  .sint_q        (sint_q),
  .tbase_q       (tbase_q)
);

// File: tb/sim_ctrl_reg_bank.sv
module sim_ctrl_reg_bank;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int TL_W = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      idx_i = '0;
  logic            wr_en_i = 1'b0;
  logic            rd_en_i = 1'b0;
  logic [DW-1:0]   wr_data_i = '0;
  logic [1:0]      priv_i = '0;
  logic [TL_W-1:0] tl_i = '0;
  logic [DW-1:0]   rd_data_o;
  logic [1:0]      fault_o;
  logic            irq_recheck_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] m_sint, m_tcmp, m_scmp, m_tstate, m_tbase;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctrl_reg_bank u0 (
    .clk(clk), .rst_n(rst_n), .idx_i(idx_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wr_data_i(wr_data_i), .priv_i(priv_i), .tl_i(tl_i),
    .rd_data_o(rd_data_o), .fault_o(fault_o), .irq_recheck_o(irq_recheck_o)
  );

  function automatic int level_of(input logic [63:0] v);
    for (int b = 15; b >= 1; b--) if (v[b]) return b;
    return 0;
  endfunction

  // Fault codes: 0 none, 1 privileged-opcode, 2 illegal-instruction.
  function automatic int exp_fault(input int ix, input bit w, input bit r, input int pm, input int t);
    if (!w && !r) return 0;
    if (ix >= 8) return 2;
    if ((ix == 1 || ix == 2) && r) return 2;
    if (ix == 5 && t == 0) return 2;
    if (ix == 7 && w) return 2;
    if (pm == 0 && ix <= 4) return 1;
    return 0;
  endfunction

  function automatic logic [63:0] exp_read(input int ix);
    case (ix)
      0: return m_sint;
      3: return m_tcmp;
      4: return m_scmp;
      5: return m_tstate;
      6: return m_tbase;
      7: return 64'h0000_0000_0003_0608;
      default: return 64'd0;
    endcase
  endfunction

  function automatic string tag_of(input int ix);
    case (ix)
      0: return "R3/R10";
      1: return "R2";
      2: return "R1";
      3, 4: return "R3";
      5: return "R4";
      6: return "R5";
      7: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input int ix, input bit w, input bit r, input logic [63:0] d,
                     input int pm, input int t);
    int ef;
    bit pulse;
    logic [63:0] nv;
    @(negedge clk);
    idx_i = 4'(ix); wr_en_i = w; rd_en_i = r; wr_data_i = d;
    priv_i = 2'(pm); tl_i = TL_W'(t);
    #1;
    ef = exp_fault(ix, w, r, pm, t);
    chk({tag_of(ix), " fault"}, 64'(fault_o), 64'(ef));
    if (r) chk({ef != 0 ? "R7" : tag_of(ix), " rdata"}, rd_data_o, ef == 0 ? exp_read(ix) : 64'd0);
    pulse = 0;
    if (w && ef == 0) begin
      case (ix)
        0: nv = d;
        1: nv = m_sint | d;
        2: nv = m_sint & ~d;
        default: nv = m_sint;
      endcase
      if (ix <= 2) begin
        pulse = level_of(nv) > level_of(m_sint);
        m_sint = nv;
      end
      if (ix == 3) m_tcmp = d;
      if (ix == 4) m_scmp = d;
      if (ix == 5) m_tstate = d;
      if (ix == 6) m_tbase = d & ~64'h7FFF;
    end
    @(posedge clk); #1;
    chk("R8 recheck", 64'(irq_recheck_o), 64'(pulse));
    wr_en_i = 0; rd_en_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_sint = 0; m_tcmp = 0; m_scmp = 0; m_tstate = 0; m_tbase = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R9 recheck reset", 64'(irq_recheck_o), 64'd0);
    chk("R7 idle fault", 64'(fault_o), 64'd0);
    // R9: all registers read zero after reset
    foreach (m_sint[k]) if (k == 0) begin
      acc(0, 0, 1, 0, 2, 1); acc(3, 0, 1, 0, 2, 1); acc(4, 0, 1, 0, 2, 1);
      acc(5, 0, 1, 0, 2, 1); acc(6, 0, 1, 0, 2, 1);
    end
    // R6 version read and write fault
    acc(7, 0, 1, 0, 0, 0);
    acc(7, 1, 0, 64'hFFFF, 2, 1);
    // R8 level movements
    acc(0, 1, 0, 64'h0000_0000_0000_0010, 1, 0);  // level 4 from 0: pulse
    acc(1, 1, 0, 64'h0000_0000_0000_8000, 1, 0);  // to 15: pulse
    acc(1, 1, 0, 64'h0000_0000_0000_0008, 1, 0);  // stays 15: none
    acc(2, 1, 0, 64'h0000_0000_0000_8000, 1, 0);  // falls to 4: none
    acc(1, 1, 0, 64'h0000_0000_0000_0001, 1, 0);  // bit 0: none
    acc(1, 1, 0, 64'h0000_0000_0001_0000, 1, 0);  // bit 16: none
    acc(0, 0, 1, 0, 1, 0);                         // R1/R2 read-back
    acc(2, 1, 0, 64'h0000_0000_0001_0011, 1, 0);  // R1 clear over non-zero base
    acc(0, 0, 1, 0, 1, 0);
    // R3 user blocked
    acc(0, 1, 0, 64'hFFFF, 0, 3);
    acc(1, 1, 0, 64'hFFFF, 0, 3);
    acc(3, 1, 0, 64'h55, 0, 3);
    acc(0, 0, 1, 0, 1, 0);
    acc(3, 0, 1, 0, 1, 0);
    // R4 trap-state at level 0, then inside a trap
    acc(5, 1, 0, 64'hABCD, 2, 0);
    acc(5, 0, 1, 0, 2, 0);
    acc(5, 1, 0, 64'hABCD, 2, 2);
    acc(5, 0, 1, 0, 2, 2);
    // R5 trap base low bits
    acc(6, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 2, 0);
    acc(6, 0, 1, 0, 2, 0);
    // R7 unimplemented and alias reads
    acc(9, 0, 1, 0, 2, 1);
    acc(15, 1, 0, 64'h1, 2, 1);
    acc(1, 0, 1, 0, 2, 1);
    // Random mix with a fixed seed
    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      int ix, pm, t;
      bit w;
      logic [63:0] d;
      ix = $urandom % 16;
      pm = $urandom % 3;
      t = $urandom % 4;
      w = $urandom % 2;
      d = {$urandom, $urandom};
      if ($urandom % 2) d = d & 64'h0000_0000_0000_FFFF;
      acc(ix, w, !w, d, pm, t);
    end
    finish_run();
  end

endmodule